// File: doc/BRIEF.md
# Overlapped Convert/Arithmetic Issue Controller

This block sequences instruction tokens through two execution resources of a floating-point coprocessor: a format converter and an arithmetic engine. An arithmetic token first has its external operand converted to the internal format, then runs in the arithmetic engine. A move-out token converts a register value to an external format and hands it to the bus side as a transfer pulse. Both resources are modelled here as fixed-latency counters with start/done handshakes. The real datapaths sit outside this block.

The converter may run ahead while the arithmetic engine is still computing. It parks a converted operand until the engine's final (rounding) cycle, and is then free for the next token. Overlap is granted only to single, double and extended binary operands whose registers do not collide with the destination of the instruction in the engine. Integer and packed-decimal operands serialise: they wait until the engine is empty. The host polls a two-bit response code and presents tokens with a valid/ready pair.

Top module: `ovl_overlap_ctrl`

## Requirements
- R1: Conversion takes CVT_LAT_BIN cycles for formats 0, 1, 2 (single, double, extended) and CVT_LAT_SLOW cycles for formats 3 (integer) and 4 (packed). A move-out (issue_op=1) accepted in cycle c pulses xfer_valid in cycle c+L+1, with xfer_reg equal to its source index.
- R2: An arithmetic token (issue_op=0) accepted in cycle c into an empty block pulses wb_valid in cycle c+L+APU_LAT+1, with wb_reg equal to its destination index.
- R3: A binary-format token with no register conflict is accepted as soon as the converter is empty, even while the arithmetic engine is busy.
- R4: While the converter holds a converted operand that waits for the engine, issue_ready is low and resp reads busy.
- R5: The held operand enters the engine only in the engine's last (rounding) cycle. The next arithmetic write-back therefore follows the previous one by exactly APU_LAT cycles.
- R6: A token whose source or destination index equals the destination of the busy engine's instruction is not accepted until the engine is empty.
- R7: A token in format 3 or 4 is accepted only when both the converter and the engine are empty.
- R8: resp reads 0 (idle) when both units are empty and no output pulse is pending. It reads 2 (busy) when the converter is occupied or when the presented token cannot be accepted. Otherwise it reads 1 (ready).
- R9: After reset, issue_ready is high, resp reads idle, and wb_valid and xfer_valid are low.
- R10: For the sequence multiply, multiply, move-out on distinct registers, the second write-back arrives CVT_LAT_BIN+2*APU_LAT+1 cycles after the first token is accepted. This is the first instruction's full time plus the second's compute time. The move-out completes before that write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Host presents a token |
| issue_op | input | 1 | 0 arithmetic, 1 move-out |
| issue_fmt | input | 3 | Operand format code, 0..4 |
| issue_src | input | REG_W | Source register index |
| issue_dst | input | REG_W | Destination register index |
| issue_ready | output | 1 | Token would be accepted this cycle |
| resp | output | 2 | Host response code: 0 idle, 1 ready, 2 busy |
| wb_valid | output | 1 | Arithmetic result written back |
| wb_reg | output | REG_W | Register written by that result |
| xfer_valid | output | 1 | Move-out data handed to bus side |
| xfer_reg | output | REG_W | Register read by that move-out |

## Verification
The converter and engine states are visible at the ports as the cycle in which issue_ready rises and the spacing of wb_valid and xfer_valid pulses. A lost hold state shows up as a move-out accepted before the engine's rounding cycle. An early handover shows as two write-backs closer than APU_LAT cycles. A missed conflict shows as acceptance one cycle after the converter empties, instead of after the engine empties. Each of these differs from the expected cycle by several cycles, and the difference appears within one instruction's latency.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    CU_IDLE = 2'd0,
    CU_RUN  = 2'd1,
    CU_HOLD = 2'd2
  } cu_state_e;

  localparam logic [1:0] RESP_IDLE  = 2'd0;
  localparam logic [1:0] RESP_READY = 2'd1;
  localparam logic [1:0] RESP_BUSY  = 2'd2;

  localparam logic OP_ARITH   = 1'b0;
  localparam logic OP_MOVEOUT = 1'b1;

  localparam logic [2:0] FMT_LAST_BIN = 3'd2;

  function automatic logic fmt_is_slow(input logic [2:0] fmt);
    return fmt > FMT_LAST_BIN;
  endfunction
endpackage

// File: rtl/ovl_cvt_unit.sv
module ovl_cvt_unit #(
  parameter int LAT_BIN  = 2,
  parameter int LAT_SLOW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic slow,
  output logic busy,
  output logic done
);
  localparam int LMAX = (LAT_BIN > LAT_SLOW) ? LAT_BIN : LAT_SLOW;
  localparam int CW   = $clog2(LMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = slow ? CW'(LAT_SLOW) : CW'(LAT_BIN);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  assign cnt_en = start || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/ovl_apu_unit.sv
module ovl_apu_unit #(
  parameter int LAT = 8,
  parameter int RW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] start_dst,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] dst
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [RW-1:0] dst_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CW'(LAT);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  assign cnt_en = start || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dst_q <= '0;
    else if (start)
      dst_q <= start_dst;
  end

  assign busy = (cnt_q != '0);
  // final count is the rounding cycle
  assign done = (cnt_q == CW'(1));
  assign dst  = dst_q;
endmodule

// File: rtl/ovl_issue_check.sv
module ovl_issue_check #(
  parameter int RW = 3
) (
  input  logic          cu_idle,
  input  logic          apu_busy,
  input  logic [RW-1:0] apu_dst,
  input  logic [2:0]    fmt,
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] dst,
  output logic          slow,
  output logic          can_accept
);
  import ovl_pkg::*;

  logic conflict;

  assign slow       = fmt_is_slow(fmt);
  assign conflict   = apu_busy && ((src == apu_dst) || (dst == apu_dst));
  assign can_accept = cu_idle && !conflict && !(slow && apu_busy);
endmodule

// File: rtl/ovl_overlap_ctrl.sv
module ovl_overlap_ctrl #(
  parameter int REG_W        = 3,
  parameter int CVT_LAT_BIN  = 2,
  parameter int CVT_LAT_SLOW = 6,
  parameter int APU_LAT      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             issue_op,
  input  logic [2:0]       issue_fmt,
  input  logic [REG_W-1:0] issue_src,
  input  logic [REG_W-1:0] issue_dst,
  output logic             issue_ready,
  output logic [1:0]       resp,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg,
  output logic             xfer_valid,
  output logic [REG_W-1:0] xfer_reg
);
  import ovl_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cu_state_e        cu_q, cu_d;
  logic             cu_idle, cu_hold;
  logic             tok_op_q;
  logic [REG_W-1:0] tok_src_q, tok_dst_q;

  logic             accept, can_accept, slow;
  logic             cvt_busy, cvt_done;
  logic             apu_start, apu_busy, apu_done, apu_free;
  logic [REG_W-1:0] apu_dst;

  logic             wb_d, xfer_d;
  logic             wb_q, xfer_q;
  logic [REG_W-1:0] wb_reg_q, xfer_reg_q;

  assign cu_idle = (cu_q == CU_IDLE);
  assign cu_hold = (cu_q == CU_HOLD);

  ovl_issue_check #(.RW(REG_W)) u_check (
    .cu_idle    (cu_idle),
    .apu_busy   (apu_busy),
    .apu_dst    (apu_dst),
    .fmt        (issue_fmt),
    .src        (issue_src),
    .dst        (issue_dst),
    .slow       (slow),
    .can_accept (can_accept)
  );

  assign issue_ready = can_accept;
  assign accept      = issue_valid && can_accept;

  ovl_cvt_unit #(.LAT_BIN(CVT_LAT_BIN), .LAT_SLOW(CVT_LAT_SLOW)) u_cvt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (accept),
    .slow  (slow),
    .busy  (cvt_busy),
    .done  (cvt_done)
  );

  ovl_apu_unit #(.LAT(APU_LAT), .RW(REG_W)) u_apu (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (apu_start),
    .start_dst (tok_dst_q),
    .busy      (apu_busy),
    .done      (apu_done),
    .dst       (apu_dst)
  );

  // engine can take an operand when empty or in its rounding cycle
  assign apu_free = !apu_busy || apu_done;

  always_comb begin
    cu_d = cu_q;
    unique case (cu_q)
      CU_IDLE: if (accept) cu_d = CU_RUN;
      CU_RUN: begin
        if (cvt_done) begin
          if (tok_op_q == OP_MOVEOUT || apu_free)
            cu_d = CU_IDLE;
          else
            cu_d = CU_HOLD;
        end
      end
      CU_HOLD: if (apu_free) cu_d = CU_IDLE;
      default: cu_d = CU_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)
      cu_q <= CU_IDLE;
    else
      cu_q <= cu_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tok_op_q  <= OP_ARITH;
      tok_src_q <= '0;
      tok_dst_q <= '0;
    end else if (accept) begin
      tok_op_q  <= issue_op;
      tok_src_q <= issue_src;
      tok_dst_q <= issue_dst;
    end
  end

  assign apu_start = ((cu_q == CU_RUN) && cvt_done && (tok_op_q == OP_ARITH) && apu_free)
                  || (cu_hold && apu_free);

  assign xfer_d = (cu_q == CU_RUN) && cvt_done && (tok_op_q == OP_MOVEOUT);
  assign wb_d   = apu_done;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wb_q   <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      wb_q   <= wb_d;
      xfer_q <= xfer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)
      wb_reg_q <= '0;
    else if (wb_d)
      wb_reg_q <= apu_dst;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)
      xfer_reg_q <= '0;
    else if (xfer_d)
      xfer_reg_q <= tok_src_q;
  end

  always_comb begin
    if (cu_idle && !cvt_busy && !apu_busy && !wb_q && !xfer_q)
      resp = RESP_IDLE;
    else if (!cu_idle || (issue_valid && !can_accept))
      resp = RESP_BUSY;
    else
      resp = RESP_READY;
  end

  assign wb_valid   = wb_q;
  assign wb_reg     = wb_reg_q;
  assign xfer_valid = xfer_q;
  assign xfer_reg   = xfer_reg_q;
endmodule

// File: rtl/ovl_overlap_chk.sv
module ovl_overlap_chk #(
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic          issue_ready,
  input logic [2:0]    issue_fmt,
  input logic [RW-1:0] issue_src,
  input logic [RW-1:0] issue_dst,
  input logic          cu_hold,
  input logic          cvt_done,
  input logic          apu_start,
  input logic          apu_busy,
  input logic          apu_done,
  input logic [RW-1:0] apu_dst,
  input logic          wb_valid,
  input logic          xfer_valid,
  input logic [1:0]    resp
);
  AST_XFER_FOLLOWS_CVT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $past(cvt_done)); // R1

  AST_WB_FOLLOWS_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(apu_done)); // R2

  AST_HOLD_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    cu_hold |-> (!issue_ready && resp == 2'd2)); // R4

  AST_HANDOVER_ON_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (apu_start && apu_busy) |-> apu_done); // R5

  AST_NO_CONFLICT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && apu_busy) |-> (issue_src != apu_dst && issue_dst != apu_dst)); // R6

  AST_SLOW_FMT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && issue_fmt > 3'd2) |-> !apu_busy); // R7

  AST_IDLE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (resp == 2'd0) |-> (!apu_busy && !cu_hold && !wb_valid && !xfer_valid)); // R8
endmodule

bind ovl_overlap_ctrl ovl_overlap_chk #(.RW(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_fmt   (issue_fmt),
  .issue_src   (issue_src),
  .issue_dst   (issue_dst),
  .cu_hold     (cu_hold),
  .cvt_done    (cvt_done),
  .apu_start   (apu_start),
  .apu_busy    (apu_busy),
  .apu_done    (apu_done),
  .apu_dst     (apu_dst),
  .wb_valid    (wb_valid),
  .xfer_valid  (xfer_valid),
  .resp        (resp)
);

// File: tb/sim_ovl_overlap_ctrl.sv
`timescale 1ns/1ps
module sim_ovl_overlap_ctrl;
  localparam int RW = 3;
  localparam int LB = 2;
  localparam int LS = 6;
  localparam int A  = 8;

  localparam int EXP_AB = LB + A + 1;
  localparam int EXP_AS = LS + A + 1;
  localparam int EXP_MB = LB + 1;
  localparam int EXP_MS = LS + 1;

  // {op, fmt, src, dst, latency}
  localparam logic [15:0] VEC [9] = '{
    {1'b0, 3'd0, 3'd0, 3'd1, 6'(EXP_AB)},
    {1'b0, 3'd1, 3'd2, 3'd3, 6'(EXP_AB)},
    {1'b0, 3'd2, 3'd4, 3'd5, 6'(EXP_AB)},
    {1'b0, 3'd3, 3'd1, 3'd6, 6'(EXP_AS)},
    {1'b0, 3'd4, 3'd3, 3'd7, 6'(EXP_AS)},
    {1'b1, 3'd0, 3'd2, 3'd2, 6'(EXP_MB)},
    {1'b1, 3'd2, 3'd7, 3'd7, 6'(EXP_MB)},
    {1'b1, 3'd3, 3'd5, 3'd5, 6'(EXP_MS)},
    {1'b1, 3'd4, 3'd6, 3'd6, 6'(EXP_MS)}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic          issue_op = 1'b0;
  logic [2:0]    issue_fmt = 3'd0;
  logic [RW-1:0] issue_src = '0;
  logic [RW-1:0] issue_dst = '0;
  logic          issue_ready;
  logic [1:0]    resp;
  logic          wb_valid, xfer_valid;
  logic [RW-1:0] wb_reg, xfer_reg;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 0;

  int ev_kind [64];
  int ev_reg  [64];
  int ev_cyc  [64];
  int ev_n = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ovl_overlap_ctrl #(.REG_W(RW), .CVT_LAT_BIN(LB), .CVT_LAT_SLOW(LS), .APU_LAT(A)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_fmt(issue_fmt), .issue_src(issue_src), .issue_dst(issue_dst),
    .issue_ready(issue_ready), .resp(resp), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .xfer_valid(xfer_valid), .xfer_reg(xfer_reg)
  );

  // event log: kind 0 write-back, 1 transfer
  always @(negedge clk) begin
    if (rst_n && wb_valid && ev_n < 64) begin
      ev_kind[ev_n] = 0; ev_reg[ev_n] = int'(wb_reg); ev_cyc[ev_n] = cyc; ev_n = ev_n + 1;
    end
    if (rst_n && xfer_valid && ev_n < 64) begin
      ev_kind[ev_n] = 1; ev_reg[ev_n] = int'(xfer_reg); ev_cyc[ev_n] = cyc; ev_n = ev_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic present(input logic op, input logic [2:0] fmt,
                         input logic [RW-1:0] src, input logic [RW-1:0] dst);
    issue_op = op; issue_fmt = fmt; issue_src = src; issue_dst = dst;
    issue_valid = 1'b1;
    #1;
  endtask

  task automatic wait_acc(output int acc);
    int guard = 0;
    while (!issue_ready && guard < 200) begin
      @(negedge clk); #1; guard++;
    end
    acc = cyc;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (resp != 2'd0 && guard < 200) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic wait_events(input int count);
    int guard = 0;
    while (ev_n < count && guard < 200) begin
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int base, a0, a1, a2;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 ready in reset", int'(issue_ready), 1);
    chk("R9 resp in reset", int'(resp), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 ready after reset", int'(issue_ready), 1);
    chk("R9 resp after reset", int'(resp), 0);
    chk("R9 wb low", int'(wb_valid), 0);
    chk("R9 xfer low", int'(xfer_valid), 0);

    // R1 R2: single tokens from an empty block, table driven
    for (int i = 0; i < 9; i++) begin
      wait_idle();
      base = ev_n;
      present(VEC[i][15], VEC[i][14:12], VEC[i][11:9], VEC[i][8:6]);
      wait_acc(a0);
      wait_events(base + 1);
      if (VEC[i][15]) begin
        chk("R1 move-out kind", ev_kind[base], 1);
        chk("R1 move-out reg", ev_reg[base], int'(VEC[i][11:9]));
        chk("R1 move-out latency", ev_cyc[base] - a0, int'(VEC[i][5:0]));
      end else begin
        chk("R2 arith kind", ev_kind[base], 0);
        chk("R2 arith reg", ev_reg[base], int'(VEC[i][8:6]));
        chk("R2 arith latency", ev_cyc[base] - a0, int'(VEC[i][5:0]));
      end
    end

    // R3 R4 R5 R10: multiply, multiply, move-out
    wait_idle();
    base = ev_n;
    present(1'b0, 3'd1, 3'd0, 3'd1);
    wait_acc(a0);
    present(1'b0, 3'd0, 3'd3, 3'd2);
    wait_acc(a1);
    chk("R3 overlapped accept cycle", a1 - a0, LB + 1);
    wait_cyc(a1 + LB + 1);
    chk("R4 ready low while holding", int'(issue_ready), 0);
    chk("R4 resp busy while holding", int'(resp), 2);
    present(1'b1, 3'd2, 3'd4, 3'd4);
    wait_acc(a2);
    chk("R4 next accept after handover", a2 - a0, LB + A + 1);
    wait_events(base + 3);
    chk("R10 first completion is write-back", ev_kind[base], 0);
    chk("R2 first write-back reg", ev_reg[base], 1);
    chk("R2 first write-back cycle", ev_cyc[base] - a0, LB + A + 1);
    chk("R10 second completion is move-out", ev_kind[base + 1], 1);
    chk("R1 move-out cycle", ev_cyc[base + 1] - a2, LB + 1);
    chk("R10 third completion is write-back", ev_kind[base + 2], 0);
    chk("R5 write-back spacing", ev_cyc[base + 2] - ev_cyc[base], A);
    chk("R10 total time", ev_cyc[base + 2] - a0 - 1, (LB + A) + A);

    // R6 R8: source conflict with engine destination
    wait_idle();
    present(1'b0, 3'd1, 3'd0, 3'd5);
    wait_acc(a0);
    wait_cyc(a0 + LB + 1);
    chk("R8 resp ready with engine busy", int'(resp), 1);
    present(1'b1, 3'd0, 3'd5, 3'd5);
    chk("R6 ready low on source conflict", int'(issue_ready), 0);
    chk("R8 resp busy on blocked token", int'(resp), 2);
    wait_acc(a1);
    chk("R6 source conflict accept cycle", a1 - a0, LB + A + 1);

    // R6: destination conflict
    wait_idle();
    present(1'b0, 3'd2, 3'd0, 3'd5);
    wait_acc(a0);
    present(1'b0, 3'd0, 3'd6, 3'd5);
    wait_acc(a1);
    chk("R6 destination conflict accept cycle", a1 - a0, LB + A + 1);

    // R7: slow format waits for empty engine
    wait_idle();
    base = ev_n;
    present(1'b0, 3'd1, 3'd0, 3'd1);
    wait_acc(a0);
    present(1'b0, 3'd3, 3'd2, 3'd3);
    wait_acc(a1);
    chk("R7 integer token accept cycle", a1 - a0, LB + A + 1);
    wait_events(base + 2);
    chk("R7 integer token write-back cycle", ev_cyc[base + 1] - a1, LS + A + 1);

    wait_idle();
    chk("R8 resp idle at end", int'(resp), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule